// File: doc/BRIEF.md
# In-System Configuration Mode Tracker

This block is the target-side state machine that records which in-system configuration mode a device is in. It has four modes. Unprogrammed is the state after power-up. Accessed means configuration access has been granted. Complete means access has just been released. Operational means the device holds a valid configuration. The surrounding test-access logic decodes each instruction and passes it in as a class. It also signals the moment an instruction is loaded into the instruction register, the moment an instruction takes effect, and a test-logic-reset. A separate programming engine supplies a done status bit.

The block moves between modes on these events alone. It reports the mode, a flag that is high only while configuration access is granted, and an I/O-safe flag. The pad logic uses that flag to keep user pins three-stated or pulled up whenever the device is not operational.

The Complete mode is the only point at which the done bit matters. A test-logic-reset, or loading any non-test instruction other than the disable instruction, resolves Complete into Operational or back into Unprogrammed. The choice depends on done at that moment.

Top module: `isc_mode_fsm`

## Requirements
- R1: After reset `mode_o` is 2'b00 (Unprogrammed) and `isc_enabled_o` is 0. The mode codes are Unprogrammed 2'b00, Accessed 2'b01, Complete 2'b10 and Operational 2'b11.
- R2: `io_safe_o` is 1 in every mode except Operational (2'b11), where it is 0.
- R3: A cycle with `ir_exec_i`=1 and class enable (`icls_i`=2'b10), in Unprogrammed or Operational, moves the mode to Accessed on the next cycle. `isc_enabled_o` is 1 exactly while the mode is Accessed.
- R4: In Unprogrammed or Operational, the mode is left unchanged by an executed instruction of class other (2'b01) or disable (2'b11), and by any instruction load.
- R5: In Accessed, an executed disable (2'b11) moves the mode to Complete. An executed other (2'b01) or enable (2'b10), or any load, keeps the mode Accessed.
- R6: In Complete, either of two events leaves the mode. One is `tlr_i`=1. The other is `ir_load_i`=1 with class other (2'b01) or enable (2'b10). The next mode is Operational if `done_i` is 1 in that cycle, and Unprogrammed if it is 0.
- R7: In Complete, loading disable (2'b11) and executing any instruction leave the mode at Complete.
- R8: Class test (2'b00) never changes the mode, whether it is loaded or executed.
- R9: `tlr_i` takes priority over an instruction event in the same cycle. Outside Complete, `tlr_i` leaves the mode unchanged and the instruction event of that cycle is ignored.
- R10: `done_i` has no effect on the mode except in the cycle in which Complete is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| tlr_i | input | 1 | Test-logic-reset event, one cycle |
| ir_load_i | input | 1 | Instruction-loaded event, one cycle |
| ir_exec_i | input | 1 | Instruction-executed event, one cycle |
| icls_i | input | 2 | Class of current instruction: 00 test, 01 other, 10 enable, 11 disable |
| done_i | input | 1 | Configuration done status |
| isc_enabled_o | output | 1 | Configuration access granted |
| mode_o | output | 2 | Current mode code |
| io_safe_o | output | 1 | Hold user I/O in a safe state |

## Verification
The assertions assume that `icls_i` describes the instruction belonging to whichever event is pulsed in that cycle. They also assume that the class is held steady only for that cycle, not across cycles. They do not assume that load and execute are exclusive: each mode listens to only one of the two events, so both may be high at once.

The stimulus sweeps every start mode against every combination of the three events, the four classes and the done bit. This covers simultaneous events and done changing while it is ignored. Each case starts from a fresh reset and a known path to its start mode.

// File: rtl/isc_mode_pkg.sv
package isc_mode_pkg;

  localparam int MODE_W = 2;
  localparam int ICLS_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_UNPROG = 2'b00,
    MODE_ACCESS = 2'b01,
    MODE_FINISH = 2'b10,
    MODE_OPER   = 2'b11
  } isc_mode_e;

  typedef enum logic [ICLS_W-1:0] {
    ICLS_TEST    = 2'b00,
    ICLS_OTHER   = 2'b01,
    ICLS_ENABLE  = 2'b10,
    ICLS_DISABLE = 2'b11
  } isc_icls_e;

  typedef struct packed {
    logic tlr;        // test-logic-reset seen
    logic ena_exec;   // enable instruction executed
    logic dis_exec;   // disable instruction executed
    logic leave_load; // non-test, non-disable instruction loaded
  } isc_trig_t;

  // Resolution of the finish mode.
  function automatic isc_mode_e settle_mode(input logic done);
    return done ? MODE_OPER : MODE_UNPROG;
  endfunction

  // Next-mode rule; reset has priority over every instruction trigger.
  function automatic isc_mode_e next_mode(input isc_mode_e cur,
                                          input isc_trig_t trg,
                                          input logic done);
    isc_mode_e nxt;
    nxt = cur;
    unique case (cur)
      MODE_UNPROG, MODE_OPER: if (!trg.tlr && trg.ena_exec) nxt = MODE_ACCESS;
      MODE_ACCESS:            if (!trg.tlr && trg.dis_exec) nxt = MODE_FINISH;
      MODE_FINISH:            if (trg.tlr || trg.leave_load) nxt = settle_mode(done);
      default:                nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/isc_trig_decode.sv
module isc_trig_decode
  import isc_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlr_i,
  input  logic              ir_load_i,
  input  logic              ir_exec_i,
  input  logic [ICLS_W-1:0] icls_i,
  output isc_trig_t         trig_o
);

  isc_icls_e cls;
  logic      is_test;
  logic      ena_exec;
  logic      dis_exec;
  logic      leave_load;

  assign cls        = isc_icls_e'(icls_i);
  assign is_test    = (cls == ICLS_TEST);
  assign ena_exec   = ir_exec_i && (cls == ICLS_ENABLE);
  assign dis_exec   = ir_exec_i && (cls == ICLS_DISABLE);
  assign leave_load = ir_load_i && !is_test && (cls != ICLS_DISABLE);

  always_comb begin
    trig_o            = '0;
    trig_o.tlr        = tlr_i;
    trig_o.ena_exec   = ena_exec;
    trig_o.dis_exec   = dis_exec;
    trig_o.leave_load = leave_load;
  end

  AST_TEST_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (icls_i == 2'b00) |-> !(trig_o.ena_exec || trig_o.dis_exec || trig_o.leave_load)); // R8

  AST_TRIG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({trig_o.ena_exec, trig_o.dis_exec}) <= 1); // R5

endmodule

// File: rtl/isc_mode_next.sv
module isc_mode_next
  import isc_mode_pkg::*;
(
  input  isc_mode_e cur_i,
  input  isc_trig_t trig_i,
  input  logic      done_i,
  output isc_mode_e nxt_o,
  output logic      moving_o
);

  assign nxt_o    = next_mode(cur_i, trig_i, done_i);
  assign moving_o = (nxt_o != cur_i);

endmodule

// File: rtl/isc_mode_fsm.sv
module isc_mode_fsm
  import isc_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlr_i,
  input  logic              ir_load_i,
  input  logic              ir_exec_i,
  input  logic [ICLS_W-1:0] icls_i,
  input  logic              done_i,
  output logic              isc_enabled_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              io_safe_o
);

  isc_trig_t trig;
  isc_mode_e mode_q;
  isc_mode_e mode_d;
  logic      moving;

  isc_trig_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .tlr_i     (tlr_i),
    .ir_load_i (ir_load_i),
    .ir_exec_i (ir_exec_i),
    .icls_i    (icls_i),
    .trig_o    (trig)
  );

  isc_mode_next u_next (
    .cur_i    (mode_q),
    .trig_i   (trig),
    .done_i   (done_i),
    .nxt_o    (mode_d),
    .moving_o (moving)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_UNPROG;
    else if (moving) mode_q <= mode_d;
  end

  assign mode_o        = mode_q;
  assign isc_enabled_o = (mode_q == MODE_ACCESS);
  assign io_safe_o     = (mode_q != MODE_OPER);

  AST_ENABLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 2'b00 || mode_o == 2'b11) && ir_exec_i && icls_i == 2'b10 && !tlr_i)
    |=> (mode_o == 2'b01 && isc_enabled_o)); // R3

  AST_DISABLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && ir_exec_i && icls_i == 2'b11 && !tlr_i) |=> mode_o == 2'b10); // R5

  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && (tlr_i || trig.leave_load) && done_i) |=> mode_o == 2'b11); // R6

  AST_FINISH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && (tlr_i || trig.leave_load) && !done_i) |=> mode_o == 2'b00); // R6

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr_i && icls_i == 2'b00) |=> $stable(mode_o)); // R8

  AST_TLR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (tlr_i && mode_o != 2'b10) |=> $stable(mode_o)); // R9

  AST_SAFE_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    isc_enabled_o |-> io_safe_o); // R2

endmodule

// File: tb/isc_mode_fsm_bench.sv
module isc_mode_fsm_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tlr_i = 1'b0;
  logic       ir_load_i = 1'b0;
  logic       ir_exec_i = 1'b0;
  logic [1:0] icls_i = 2'b00;
  logic       done_i = 1'b0;
  logic       isc_enabled_o;
  logic [1:0] mode_o;
  logic       io_safe_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_mode_fsm u_isc_mode_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tlr_i         (tlr_i),
    .ir_load_i     (ir_load_i),
    .ir_exec_i     (ir_exec_i),
    .icls_i        (icls_i),
    .done_i        (done_i),
    .isc_enabled_o (isc_enabled_o),
    .mode_o        (mode_o),
    .io_safe_o     (io_safe_o)
  );

  function automatic logic [1:0] expect_mode(input logic [1:0] s, input logic t,
                                             input logic l, input logic e,
                                             input logic [1:0] c, input logic d);
    if (s == 2'd2) begin
      if (t || (l && (c == 2'd1 || c == 2'd2))) return d ? 2'd3 : 2'd0;
      return s;
    end
    if (t) return s;
    if (s == 2'd1) return (e && c == 2'd3) ? 2'd2 : s;
    return (e && c == 2'd2) ? 2'd1 : s;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic l, input logic e,
                      input logic [1:0] c, input logic d);
    @(negedge clk);
    tlr_i = t; ir_load_i = l; ir_exec_i = e; icls_i = c; done_i = d;
    @(negedge clk);
    tlr_i = 1'b0; ir_load_i = 1'b0; ir_exec_i = 1'b0; icls_i = 2'b00; done_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reach(input logic [1:0] s);
    do_reset();
    if (s == 2'd0) return;
    step(1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    if (s == 2'd1) return;
    step(1'b0, 1'b0, 1'b1, 2'd3, 1'b0);
    if (s == 2'd2) return;
    step(1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
  endtask

  function automatic string tag_for(input logic [1:0] s, input logic t,
                                    input logic l, input logic e,
                                    input logic [1:0] c, input logic d);
    if (t && s != 2'd2) return "R9";
    if (c == 2'd0 && !t) return "R8";
    if (s == 2'd2) return (t || (l && (c == 2'd1 || c == 2'd2))) ? "R6" : "R7";
    if (s == 2'd1) return "R5";
    if (e && c == 2'd2) return "R3";
    if (d) return "R10";
    return "R4";
  endfunction

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] exp;
    do_reset();
    // R1 reset state, R2 safe flag in Unprogrammed
    check("R1 mode", mode_o, 0);
    check("R1 enabled", isc_enabled_o, 0);
    check("R2 io_safe", io_safe_o, 1);

    // Path-reach checks for each mode
    for (int s = 0; s < 4; s++) begin
      reach(2'(s));
      check("R1 path mode", mode_o, s);
      check("R3 enabled flag", isc_enabled_o, (s == 1) ? 1 : 0);
      check("R2 io_safe", io_safe_o, (s == 3) ? 0 : 1);
    end

    // Exhaustive sweep of start mode x events x class x done
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 64; v++) begin
        logic t, l, e, d;
        logic [1:0] c;
        t = v[0]; l = v[1]; e = v[2]; d = v[3]; c = 2'(v >> 4);
        reach(2'(s));
        step(t, l, e, c, d);
        exp = expect_mode(2'(s), t, l, e, c, d);
        check(tag_for(2'(s), t, l, e, c, d), mode_o, exp);
        check("R3 enabled flag", isc_enabled_o, (exp == 2'd1) ? 1 : 0);
        check("R2 io_safe", io_safe_o, (exp == 2'd3) ? 0 : 1);
      end
    end

    // R10: done toggling with no event in Unprogrammed, Accessed, Operational
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      reach(2'(s));
      step(1'b0, 1'b0, 1'b0, 2'd1, 1'b1);
      check("R10 done ignored", mode_o, s);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule